// File: doc/BRIEF.md
# Flash page-program sequencer

This engine writes a stream of bytes into a serial NOR flash through a byte-wide SPI transmit port. It splits the write into chunks that never cross a page boundary. Each chunk is sent as a complete flash programming cycle: a write-enable command, the program command with its address and data, and a wait until the flash status shows the internal write has finished. The SPI shifter is outside the block. The engine pushes bytes into its transmit queue, watches for the queue to run empty, and reads back one received byte for every byte it sends while receive direction is selected.

A job starts with a single-cycle `start` pulse that carries a byte offset, a byte count and a busy-poll limit in clock cycles. Data bytes arrive on a valid/ready stream. When every chunk has been programmed and confirmed, the engine ends the job with a one-cycle `done` pulse. It ends the job with a one-cycle `err` pulse if the offset needs more than three address bytes, or if a busy poll runs past its limit.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, `busy`, `cs_hold`, `dir_rx`, `tx_valid`, `in_ready`, `done` and `err` are all low.
- R2: A start whose offset has any of bits 31 to 24 set produces an `err` pulse in the next cycle. No byte is sent and no data is consumed.
- R3: The first chunk holds min(count, PAGE_BYTES − offset mod PAGE_BYTES) bytes. Every later chunk starts on a page boundary and holds at most PAGE_BYTES bytes. Each chunk's 24-bit address is the offset plus the bytes already written.
- R4: Every chunk opens with the write-enable opcode 0x06, pushed with `cs_hold` low as a frame of its own. The next byte is not pushed until `tx_empty` has been seen high.
- R5: The program frame is sent with `cs_hold` high and `dir_rx` low. It carries opcode 0x02, then the address as three bytes with the high byte first, then the chunk's data bytes in stream order.
- R6: `in_ready` is high only while program data is being pushed, and so only while `cs_hold` is high and `dir_rx` is low.
- R7: After the last data byte, `cs_hold` stays high until `tx_empty` is high. It then drops for at least one cycle before the status poll raises it again.
- R8: The status poll holds `dir_rx` and `cs_hold` high. It sends read-status 0x05 and ignores the byte received for it, even one with bit 0 set. It then sends 0x00 and waits for the received byte, and repeats this until a received byte has bit 0 (busy) clear. After that it lowers `cs_hold` and `dir_rx`.
- R9: A poll phase is counted from its first cycle with `dir_rx` high, that cycle being number 0. If the phase reaches cycle number `timeout_cycles` without a clear status, the engine pulses `err` and returns to idle with `cs_hold` and `dir_rx` low. It pushes no further bytes.
- R10: A clear status byte that arrives in the same cycle the poll limit is reached counts as success.
- R11: `done` pulses once, one cycle after the last chunk's clear status. A count of zero gives `done` with no bytes sent. `done` and `err` are never high together.
- R12: A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle job start, taken only when idle |
| start_offset | input | 32 | Byte offset in flash of the first byte |
| start_count | input | CNT_W | Number of bytes to write |
| timeout_cycles | input | TO_W | Limit for each busy-poll phase, in cycles |
| in_valid | input | 1 | Data byte available |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Data byte taken in this cycle when valid |
| tx_valid | output | 1 | Byte offered to the SPI transmit queue |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmit queue accepts a byte |
| tx_empty | input | 1 | Transmit queue and shifter idle |
| rx_valid | input | 1 | One received byte present |
| rx_data | input | 8 | Received byte |
| cs_hold | output | 1 | Keep chip select asserted across bytes |
| dir_rx | output | 1 | Receive direction selected |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished, one-cycle pulse |
| err | output | 1 | Job rejected or timed out, one-cycle pulse |

## Verification
Two events can fall in the same cycle: the poll limit expiring, and a clear status byte arriving. The bench first runs a single-chunk job with a generous limit. In that run it counts the cycles from the rise of `dir_rx` to the clear status byte. It then repeats the job twice. With the limit set to exactly that count, the job must end in `done`. With the limit one cycle smaller, it must end in `err` with chip select released.

// File: rtl/flash_pp_pkg.sv
package flash_pp_pkg;

   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_PROG = 8'h02;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_FILL = 8'h00;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WREN_TX,
      S_WREN_DRAIN,
      S_PP_CMD,
      S_PP_ADDR,
      S_PP_DATA,
      S_PP_DRAIN,
      S_POLL_SETUP,
      S_POLL_CMD,
      S_POLL_CMD_RX,
      S_POLL_TX,
      S_POLL_RX
   } fpp_state_t;

endpackage

// File: rtl/fpp_chunk.sv
module fpp_chunk #(
   parameter int PAGE_BYTES = 256,
   parameter int CNT_W      = 16
) (
   input  logic [23:0]      addr,
   input  logic [CNT_W-1:0] left,
   output logic [CNT_W-1:0] len
);
   localparam int PG_W = $clog2(PAGE_BYTES);

   logic [CNT_W-1:0] room;

   assign room = CNT_W'(PAGE_BYTES) - CNT_W'(addr[PG_W-1:0]);
   assign len  = (left < room) ? left : room;

endmodule

// File: rtl/fpp_addr_bytes.sv
module fpp_addr_bytes #(
   parameter int NB = 3,
   localparam int SW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic [8*NB-1:0] addr,
   input  logic [SW-1:0]   sel,
   output logic [7:0]      byte_o
);
   logic [7:0] lanes [NB];

   for (genvar gi = 0; gi < NB; gi++) begin : g_lane
      assign lanes[gi] = addr[8*(NB-1-gi) +: 8];
   end

   always_comb begin
      byte_o = '0;
      for (int i = 0; i < NB; i++) begin
         if (sel == SW'(i)) byte_o = lanes[i];
      end
   end

endmodule

// File: rtl/fpp_poll_timer.sv
module fpp_poll_timer #(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [TO_W-1:0] limit,
   output logic            expired
);
   logic [TO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (cnt_q != '1) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = run && (cnt_q >= limit);

   AST_TIMER_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) && (limit != '0) |-> !expired) else $error("timer not cleared"); // R9

endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
   import flash_pp_pkg::*;
#(
   parameter int PAGE_BYTES = 256,
   parameter int CNT_W      = 16,
   parameter int TO_W       = 16,
   parameter int BUSY_BIT   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [31:0]      start_offset,
   input  logic [CNT_W-1:0] start_count,
   input  logic [TO_W-1:0]  timeout_cycles,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   input  logic             tx_ready,
   input  logic             tx_empty,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   output logic             cs_hold,
   output logic             dir_rx,
   output logic             busy,
   output logic             done,
   output logic             err
);
   localparam int ADDR_BYTES = 3;
   localparam int AB_W       = $clog2(ADDR_BYTES);

   initial begin
      assert (PAGE_BYTES >= 2 && (PAGE_BYTES & (PAGE_BYTES - 1)) == 0)
         else $error("PAGE_BYTES must be a power of two");
      assert (CNT_W > $clog2(PAGE_BYTES)) else $error("CNT_W too narrow for a page");
      assert (BUSY_BIT >= 0 && BUSY_BIT < 8) else $error("BUSY_BIT out of byte");
      assert (TO_W >= 1) else $error("TO_W must be positive");
   end

   fpp_state_t       state_q;
   logic [23:0]      addr_q;
   logic [CNT_W-1:0] left_q;
   logic [CNT_W-1:0] chunk_q;
   logic [AB_W-1:0]  abyte_q;
   logic [TO_W-1:0]  limit_q;
   logic             done_q, err_q;

   logic [CNT_W-1:0] chunk_len;
   logic [7:0]       addr_byte;
   logic             expired, clear_now, abort, tx_fire, poll_ph;

   fpp_chunk #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_chunk (
      .addr(addr_q), .left(left_q), .len(chunk_len));

   fpp_addr_bytes #(.NB(ADDR_BYTES)) u_abytes (
      .addr(addr_q), .sel(abyte_q), .byte_o(addr_byte));

   fpp_poll_timer #(.TO_W(TO_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(poll_ph), .limit(limit_q), .expired(expired));

   always_comb begin
      poll_ph = 1'b0;
      case (state_q)
         S_POLL_SETUP, S_POLL_CMD, S_POLL_CMD_RX, S_POLL_TX, S_POLL_RX: poll_ph = 1'b1;
         default: poll_ph = 1'b0;
      endcase
   end

   assign clear_now = (state_q == S_POLL_RX) && rx_valid && !rx_data[BUSY_BIT];
   assign abort     = poll_ph && expired && !clear_now;

   always_comb begin
      tx_valid = 1'b0;
      tx_data  = OP_FILL;
      case (state_q)
         S_WREN_TX: begin tx_valid = 1'b1;     tx_data = OP_WREN;   end
         S_PP_CMD:  begin tx_valid = 1'b1;     tx_data = OP_PROG;   end
         S_PP_ADDR: begin tx_valid = 1'b1;     tx_data = addr_byte; end
         S_PP_DATA: begin tx_valid = in_valid; tx_data = in_data;   end
         S_POLL_CMD: begin tx_valid = 1'b1;    tx_data = OP_RDSR;   end
         S_POLL_TX: begin tx_valid = 1'b1;     tx_data = OP_FILL;   end
         default: ;
      endcase
      if (abort) tx_valid = 1'b0;
   end

   assign tx_fire  = tx_valid && tx_ready;
   assign in_ready = (state_q == S_PP_DATA) && tx_ready;

   always_comb begin
      case (state_q)
         S_PP_CMD, S_PP_ADDR, S_PP_DATA, S_PP_DRAIN,
         S_POLL_CMD, S_POLL_CMD_RX, S_POLL_TX, S_POLL_RX: cs_hold = 1'b1;
         default: cs_hold = 1'b0;
      endcase
   end

   assign dir_rx = poll_ph;
   assign busy   = (state_q != S_IDLE);
   assign done   = done_q;
   assign err    = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
         chunk_q <= '0;
         abyte_q <= '0;
         limit_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (abort) begin
            state_q <= S_IDLE;
            err_q   <= 1'b1;
         end else begin
            case (state_q)
               S_IDLE: if (start) begin
                  if (start_offset[31:24] != 8'h00) begin
                     err_q <= 1'b1;
                  end else if (start_count == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     addr_q  <= start_offset[23:0];
                     left_q  <= start_count;
                     limit_q <= timeout_cycles;
                     state_q <= S_WREN_TX;
                  end
               end
               S_WREN_TX: if (tx_fire) begin
                  chunk_q <= chunk_len;
                  state_q <= S_WREN_DRAIN;
               end
               S_WREN_DRAIN: if (tx_empty) state_q <= S_PP_CMD;
               S_PP_CMD: if (tx_fire) begin
                  abyte_q <= '0;
                  state_q <= S_PP_ADDR;
               end
               S_PP_ADDR: if (tx_fire) begin
                  abyte_q <= abyte_q + 1'b1;
                  if (abyte_q == AB_W'(ADDR_BYTES - 1)) state_q <= S_PP_DATA;
               end
               S_PP_DATA: if (tx_fire) begin
                  addr_q  <= addr_q + 24'd1;
                  left_q  <= left_q - 1'b1;
                  chunk_q <= chunk_q - 1'b1;
                  if (chunk_q == CNT_W'(1)) state_q <= S_PP_DRAIN;
               end
               S_PP_DRAIN: if (tx_empty) state_q <= S_POLL_SETUP;
               S_POLL_SETUP: state_q <= S_POLL_CMD;
               S_POLL_CMD: if (tx_fire) state_q <= S_POLL_CMD_RX;
               S_POLL_CMD_RX: if (rx_valid) state_q <= S_POLL_TX;
               S_POLL_TX: if (tx_fire) state_q <= S_POLL_RX;
               S_POLL_RX: if (rx_valid) begin
                  if (clear_now) begin
                     if (left_q == '0) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                     end else begin
                        state_q <= S_WREN_TX;
                     end
                  end else begin
                     state_q <= S_POLL_TX;
                  end
               end
               default: state_q <= S_IDLE;
            endcase
         end
      end
   end

   AST_ADDR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && (start_offset[31:24] != 8'h00) |=> err && !tx_valid && !busy)
      else $error("wide offset accepted"); // R2
   AST_WREN_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !cs_hold |-> tx_data == OP_WREN) else $error("stray byte without hold"); // R4
   AST_DATA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> cs_hold && !dir_rx) else $error("data taken outside burst"); // R6
   AST_HOLD_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_hold) |-> $past(tx_empty)) else $error("hold raised before drain"); // R7
   AST_POLL_OPCODES: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && dir_rx |-> (tx_data == OP_RDSR || tx_data == OP_FILL))
      else $error("bad byte in poll"); // R8
   AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !cs_hold && !dir_rx && !busy) else $error("err without release"); // R9
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err)) else $error("done and err together"); // R11

endmodule

// File: tb/flash_page_writer_test.sv
module flash_page_writer_test;
   localparam int CLK_PERIOD = 10;
   localparam int LOGN = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_offset = '0;
   logic [15:0] start_count = '0;
   logic [15:0] timeout_cycles = '0;
   logic        in_valid, in_ready, tx_valid, cs_hold, dir_rx, busy, done, err;
   logic [7:0]  in_data, tx_data;
   logic        tx_ready = 1'b1;
   logic        tx_empty = 1'b1;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;

   int total = 0, bad = 0;
   int busy_cfg = 0, busy_left = 0;
   logic clr = 1'b0, src_en = 1'b0, stall = 1'b0;
   int src_idx = 0, st = 0, log_n = 0;
   logic [7:0] q[$];
   logic [7:0] log_b [LOGN];
   logic       log_h [LOGN];
   logic       log_d [LOGN];
   logic [7:0] exp_b [LOGN];
   logic       exp_h [LOGN];
   logic       exp_d [LOGN];
   string      exp_t [LOGN];
   int exp_n = 0;
   int pk = 0, last_k = 0, gap_bad = 0;
   logic prev_dir = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   assign in_valid = src_en && !stall;
   assign in_data  = pat(src_idx);

   flash_page_writer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
      .start_count(start_count), .timeout_cycles(timeout_cycles),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_empty(tx_empty),
      .rx_valid(rx_valid), .rx_data(rx_data), .cs_hold(cs_hold), .dir_rx(dir_rx),
      .busy(busy), .done(done), .err(err));

   // SPI queue, shifter and flash status model
   always @(posedge clk) begin
      logic [7:0] b;
      rx_valid <= 1'b0;
      if (clr) begin
         log_n = 0;
         src_idx <= 0;
      end else begin
         if (tx_valid && tx_ready) begin
            q.push_back(tx_data);
            if (log_n < LOGN) begin
               log_b[log_n] = tx_data; log_h[log_n] = cs_hold; log_d[log_n] = dir_rx;
               log_n++;
            end
         end
         if (in_valid && in_ready) src_idx <= src_idx + 1;
      end
      stall <= (src_idx % 4 == 3) ? ~stall : 1'b0;
      if (q.size() > 0) begin
         if (st == 2) begin
            b = q.pop_front();
            st = 0;
            if (dir_rx) begin
               rx_valid <= 1'b1;
               if (b == 8'h05) begin rx_data <= 8'hFF; busy_left = busy_cfg; end
               else if (busy_left > 0) begin rx_data <= 8'h01; busy_left--; end
               else rx_data <= 8'h00;
            end
         end else st++;
      end
      tx_empty <= (q.size() == 0);
      tx_ready <= (q.size() < 3);
   end

   // poll-phase cycle index and hold gap monitor
   always @(negedge clk) begin
      if (dir_rx) begin
         if (!prev_dir) begin
            pk = 0;
            if (cs_hold) gap_bad++;
         end else pk++;
         if (rx_valid && !rx_data[0]) last_k = pk;
      end
      prev_dir = dir_rx;
   end

   task automatic check(input bit ok, input string tag, input longint act,
                        input longint expv, input string what);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic clear_log(input int bcfg);
      @(negedge clk);
      busy_cfg = bcfg;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic kick(input logic [31:0] off, input int cnt, input int to);
      @(negedge clk);
      start = 1'b1; start_offset = off; start_count = 16'(cnt); timeout_cycles = 16'(to);
      src_en = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_end(output bit got_done, output bit got_err);
      got_done = 1'b0; got_err = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         if (done || err) begin got_done = done; got_err = err; break; end
         @(negedge clk);
      end
   endtask

   task automatic ex(input logic [7:0] b, input logic h, input logic d, input string t);
      exp_b[exp_n] = b; exp_h[exp_n] = h; exp_d[exp_n] = d; exp_t[exp_n] = t;
      exp_n++;
   endtask

   task automatic build_expect(input int off, input int cnt, input int bcfg);
      int a, left, di, len;
      a = off; left = cnt; di = 0; exp_n = 0;
      while (left > 0) begin
         len = 256 - (a % 256);
         if (left < len) len = left;
         ex(8'h06, 0, 0, "R4");
         ex(8'h02, 1, 0, "R5");
         ex(8'(a >> 16), 1, 0, "R3");
         ex(8'(a >> 8), 1, 0, "R3");
         ex(8'(a), 1, 0, "R3");
         for (int j = 0; j < len; j++) begin ex(pat(di), 1, 0, "R5"); di++; end
         ex(8'h05, 1, 1, "R8");
         for (int j = 0; j <= bcfg; j++) ex(8'h00, 1, 1, "R8");
         a += len; left -= len;
      end
   endtask

   task automatic compare_log(input string what);
      check(log_n == exp_n, "R3", log_n, exp_n, {what, " byte count"});
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         if (log_b[i] != exp_b[i] || log_h[i] != exp_h[i] || log_d[i] != exp_d[i]) begin
            check(1'b0, exp_t[i], {log_b[i], 7'b0, log_h[i], 7'b0, log_d[i]},
                  {exp_b[i], 7'b0, exp_h[i], 7'b0, exp_d[i]}, {what, " byte/hold/dir"});
            break;
         end
      end
      check(log_n == exp_n && log_n > 0, "R5", log_n, exp_n, {what, " sequence complete"});
   endtask

   task automatic good_job(input int off, input int cnt, input int bcfg, input string what);
      bit gd, ge;
      clear_log(bcfg);
      gap_bad = 0;
      kick(32'(off), cnt, 4000);
      wait_end(gd, ge);
      check(gd && !ge, "R11", {gd, ge}, 2'b10, {what, " done pulse"});
      @(negedge clk);
      check(!done && !busy && !cs_hold && !dir_rx, "R8", {done, busy, cs_hold, dir_rx}, 0,
            {what, " released after done"});
      check(src_idx == cnt, "R6", src_idx, cnt, {what, " bytes consumed"});
      check(gap_bad == 0, "R7", gap_bad, 0, {what, " hold gap before poll"});
      build_expect(off, cnt, bcfg);
      compare_log(what);
      src_en = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(!busy && !cs_hold && !dir_rx && !tx_valid && !in_ready && !done && !err, "R1",
            {busy, cs_hold, dir_rx, tx_valid, in_ready, done, err}, 0, "reset outputs");
   endtask

   task automatic t_bad_addr;
      bit gd, ge;
      clear_log(0);
      kick(32'h0100_0000, 5, 100);
      wait_end(gd, ge);
      check(ge && !gd, "R2", {gd, ge}, 2'b01, "wide offset error");
      repeat (5) @(negedge clk);
      check(log_n == 0 && src_idx == 0 && !busy, "R2", log_n + src_idx, 0, "no traffic on reject");
      src_en = 1'b0;
   endtask

   task automatic t_zero;
      bit gd, ge;
      clear_log(0);
      kick(32'h40, 0, 100);
      wait_end(gd, ge);
      check(gd && !ge, "R11", {gd, ge}, 2'b10, "zero count done");
      repeat (5) @(negedge clk);
      check(log_n == 0, "R11", log_n, 0, "zero count sends nothing");
      src_en = 1'b0;
   endtask

   task automatic t_timeout;
      bit gd, ge;
      int n0;
      clear_log(60000);
      kick(32'h300, 4, 60);
      wait_end(gd, ge);
      check(ge && !gd, "R9", {gd, ge}, 2'b01, "busy forever times out");
      check(!cs_hold && !dir_rx, "R9", {cs_hold, dir_rx}, 0, "released on timeout");
      n0 = log_n;
      repeat (30) @(negedge clk);
      check(log_n == n0 && !busy, "R9", log_n, n0, "no bytes after timeout");
      src_en = 1'b0;
   endtask

   task automatic t_same_cycle;
      bit gd, ge;
      int k;
      good_job(16, 8, 2, "limit probe");
      k = last_k;
      check(k > 2, "R10", k, 3, "measured clear-status cycle");
      clear_log(2);
      kick(32'd16, 8, k);
      wait_end(gd, ge);
      check(gd && !ge, "R10", {gd, ge}, 2'b10, "clear status at limit wins");
      src_en = 1'b0;
      clear_log(2);
      kick(32'd16, 8, k - 1);
      wait_end(gd, ge);
      check(ge && !gd, "R9", {gd, ge}, 2'b01, "limit one short expires");
      src_en = 1'b0;
   endtask

   task automatic t_start_busy;
      bit gd, ge;
      clear_log(1);
      kick(32'h20, 20, 4000);
      repeat (6) @(negedge clk);
      check(busy, "R12", busy, 1, "busy during job");
      start = 1'b1; start_offset = 32'h0500_0000; start_count = 16'd3;
      @(negedge clk);
      start = 1'b0;
      wait_end(gd, ge);
      check(gd && !ge, "R12", {gd, ge}, 2'b10, "second start ignored");
      build_expect(32'h20, 20, 1);
      compare_log("start while busy");
      src_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      good_job(32'h0000F0, 40, 0, "page-crossing write");
      good_job(32'h012300, 300, 3, "aligned long write");
      good_job(32'hABCDFF, 2, 1, "one byte before boundary");
      t_bad_addr();
      t_zero();
      t_timeout();
      t_same_cycle();
      t_start_busy();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule